// File: doc/BRIEF.md
# I2C EEPROM Slave with Page Write

This block is the serial front end of a 256-byte, 8-bit-wide nonvolatile store that sits on a two-wire I2C bus as a slave. A bus master can write one byte or a burst of up to a full 16-byte page, and it can read back one byte or a run of bytes. Reads can start at an explicit word address, using a dummy write followed by a repeated START, or at the location just after the last one touched. The storage cell is modelled as a register array. The self-timed programming period of a real cell is modelled as a busy window of a parameterised number of system clock cycles.

Bytes written by the master are collected in a page buffer and reach the array only after STOP, once the busy window ends. While the window runs, the block does not acknowledge its own device address, so a master can poll for completion. An active-high write-protect input blocks data bytes. Both bus lines are oversampled by the system clock. The block only ever pulls SDA low, through an output enable.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, `busy` and `sda_oe` are low and every one of the 256 locations reads as 0x00.
- R2: The 7-bit device address is {1, dev_strap[5:0]}, followed by a R/W bit that is 0 for a write and 1 for a read. A matching address is acknowledged by pulling SDA low during the 9th clock. Any other address gets no acknowledge.
- R3: A byte write (device address, word address, one data byte, STOP) acknowledges every byte. After STOP, `busy` stays high for WR_CYCLES clock cycles, and after that the new byte reads back.
- R4: When a write continues past its first data byte, each further byte goes to the next location. Only the 4 low address bits advance, so the 17th byte of a burst overwrites the 1st byte within the same 16-byte page.
- R5: Nothing reaches the array and `busy` stays low until STOP ends the write transfer.
- R6: While `busy` is high, the device address is not acknowledged. Once `busy` falls, it is acknowledged again.
- R7: A random read (write of the word address, repeated START, read address) returns the byte stored at that word address.
- R8: A read continues for as long as the master acknowledges each byte. The address advances over the full 8 bits, so 0xFF is followed by 0x00. A missing master acknowledge ends the read.
- R9: A read that starts without a word address returns the byte at the last accessed address plus one.
- R10: While `wc_i` is high, data bytes are not acknowledged and not stored, and STOP does not start a busy window.
- R11: `sda_oe` is only ever raised while SCL is low, and it is low again once a read has ended and STOP has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| dev_strap | input | 6 | Low six bits of the device address |
| wc_i | input | 1 | Write protect, high blocks data bytes |
| sda_oe | output | 1 | When high, the block pulls SDA low |
| busy | output | 1 | High during the self-timed write window |

## Verification
Four properties are checked on every cycle:
- the pull-down only rises while the synchronised SCL is low;
- a busy window only opens right after a detected STOP;
- the window never lasts more than WR_CYCLES cycles;
- no byte enters the page buffer while busy or while write protect was high.

Whether the right data lands at the right address cannot be seen from a single cycle. Page wrap, the full-width wrap on reads, the current-address pointer, the polling refusal and the protected write are therefore only shown by the bench's bus transactions, which read back the memory afterwards.

// File: rtl/ee_pkg.sv
package ee_pkg;
   localparam int BYTE_W = 8;
   localparam int DEVA_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK
   } bus_st_e;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_d;
   logic              sda_d;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= scl_i;
               sda_ff <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= {scl_ff[STAGES-2:0], scl_i};
               sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_lvl = scl_ff[STAGES-1];
   assign sda_lvl = sda_ff[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_lvl;
         sda_d <= sda_lvl;
      end
   end

   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/ee_bus_fsm.sv
module ee_bus_fsm
   import ee_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic [DEVA_W-1:0] dev_addr,
   input  logic              wc,
   input  logic              busy,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              page_clr,
   output logic              sda_oe
);
   bus_st_e           st;
   bus_st_e           nxt;
   logic [2:0]        cnt;
   logic              got8;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] tx;
   logic              mack;
   logic              ack_oe;
   logic [ADDR_W-1:0] ptr;

   assign rd_addr = ptr;
   assign sda_oe  = ack_oe | ((st == ST_RDATA) & ~tx[BYTE_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         nxt      <= ST_IDLE;
         cnt      <= '0;
         got8     <= 1'b0;
         sh       <= '0;
         tx       <= '1;
         mack     <= 1'b0;
         ack_oe   <= 1'b0;
         ptr      <= '0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         page_clr <= 1'b0;
      end else begin
         wr_en    <= 1'b0;
         page_clr <= 1'b0;
         if (start_evt) begin
            st     <= ST_DEV;
            cnt    <= '0;
            got8   <= 1'b0;
            ack_oe <= 1'b0;
         end else if (stop_evt) begin
            st     <= ST_IDLE;
            got8   <= 1'b0;
            ack_oe <= 1'b0;
         end else begin
            case (st)
               ST_DEV, ST_WADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_lvl};
                     cnt <= cnt + 3'd1;
                     if (cnt == 3'd7) got8 <= 1'b1;
                  end else if (scl_fall && got8) begin
                     got8 <= 1'b0;
                     cnt  <= '0;
                     if (st == ST_DEV) begin
                        if (sh[BYTE_W-1:1] == dev_addr && !busy) begin
                           ack_oe <= 1'b1;
                           nxt    <= sh[0] ? ST_RDATA : ST_WADDR;
                           st     <= ST_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else if (st == ST_WADDR) begin
                        ack_oe   <= 1'b1;
                        ptr      <= sh;
                        page_clr <= 1'b1;
                        nxt      <= ST_WDATA;
                        st       <= ST_ACK;
                     end else begin
                        if (!wc) begin
                           ack_oe  <= 1'b1;
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= sh;
                           ptr     <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                           nxt     <= ST_WDATA;
                           st      <= ST_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     ack_oe <= 1'b0;
                     cnt    <= '0;
                     st     <= nxt;
                     if (nxt == ST_RDATA) begin
                        tx  <= rd_data;
                        ptr <= ptr + 1'b1;
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (cnt == 3'd7) begin
                        cnt <= '0;
                        st  <= ST_RACK;
                     end else begin
                        tx  <= {tx[BYTE_W-2:0], 1'b1};
                        cnt <= cnt + 3'd1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        tx  <= rd_data;
                        ptr <= ptr + 1'b1;
                        st  <= ST_RDATA;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   a_r11_oe_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl);
endmodule

// File: rtl/ee_store.sv
module ee_store
   import ee_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int PAGE_W    = 4,
   parameter int WR_CYCLES = 500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              page_clr,
   input  logic              stop_evt,
   input  logic              wc,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              busy
);
   localparam int DEPTH = 2 ** ADDR_W;
   localparam int PBYTES = 2 ** PAGE_W;
   localparam int HI_W = ADDR_W - PAGE_W;
   localparam int TW = $clog2(WR_CYCLES + 1);

   logic [BYTE_W-1:0] mem  [DEPTH];
   logic [BYTE_W-1:0] pbuf [PBYTES];
   logic [PBYTES-1:0] mask;
   logic [HI_W-1:0]   page_q;
   logic [TW-1:0]     tmr;

   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         for (int i = 0; i < PBYTES; i++) pbuf[i] <= '0;
         mask   <= '0;
         page_q <= '0;
         busy   <= 1'b0;
         tmr    <= '0;
      end else begin
         if (page_clr) mask <= '0;
         if (wr_en) begin
            pbuf[wr_addr[PAGE_W-1:0]] <= wr_data;
            mask[wr_addr[PAGE_W-1:0]] <= 1'b1;
            page_q                    <= wr_addr[ADDR_W-1:PAGE_W];
         end
         if (!busy) begin
            if (stop_evt && |mask) begin
               busy <= 1'b1;
               tmr  <= TW'(WR_CYCLES - 1);
            end
         end else if (tmr == '0) begin
            busy <= 1'b0;
            mask <= '0;
            for (int i = 0; i < PBYTES; i++)
               if (mask[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
         end else begin
            tmr <= tmr - 1'b1;
         end
      end
   end

   logic [TW:0] chk_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    chk_len <= '0;
      else if (busy) chk_len <= chk_len + 1'b1;
      else           chk_len <= '0;
   end

   a_r5_window_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));
   a_r3_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (chk_len < (TW+1)'(WR_CYCLES)));
   a_r6_no_fill_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !busy);
   a_r10_no_fill_protect: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(!wc));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
   import ee_pkg::*;
#(
   parameter int              ADDR_W      = 8,
   parameter int              PAGE_W      = 4,
   parameter int              WR_CYCLES   = 500,
   parameter int              SYNC_STAGES = 2,
   parameter int              STRAP_W     = 6,
   parameter logic [DEVA_W-1:0] DEV_BASE  = 7'h40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] dev_strap,
   input  logic               wc_i,
   output logic               sda_oe,
   output logic               busy
);
   if (ADDR_W != BYTE_W) begin : g_bad_addr
      $error("ADDR_W must equal the word-address byte width");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie between 1 and ADDR_W-1");
   end
   if (STRAP_W < 1 || STRAP_W >= DEVA_W) begin : g_bad_strap
      $error("STRAP_W must lie between 1 and 6");
   end
   if (WR_CYCLES < 1) begin : g_bad_wr
      $error("WR_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
   logic [DEVA_W-1:0] dev_addr;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [BYTE_W-1:0] rd_data, wr_data;
   logic              wr_en, page_clr;

   assign dev_addr = {DEV_BASE[DEVA_W-1:STRAP_W], dev_strap};

   ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
   );

   ee_bus_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
      .stop_evt(stop_evt), .dev_addr(dev_addr), .wc(wc_i), .busy(busy),
      .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .page_clr(page_clr), .sda_oe(sda_oe)
   );

   ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .page_clr(page_clr), .stop_evt(stop_evt), .wc(wc_i),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );
endmodule

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 5;
   localparam int W = 500;
   localparam logic [5:0] STRAP = 6'h2A;
   localparam logic [6:0] DEV = {1'b1, STRAP};
   localparam logic [15:0] VEC [8] = '{16'h00A5, 16'h013C, 16'h10FF, 16'h2F00,
                                       16'h8081, 16'hC37E, 16'hF018, 16'h55AA};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic wc_i = 1'b0;
   logic sda_oe, busy, bus_sda;
   int   n_chk = 0;
   int   n_fail = 0;
   logic [7:0] model [256];
   logic [7:0] rbuf [16];

   always #(CLK_PERIOD/2) clk = ~clk;
   assign bus_sda = m_sda & ~sda_oe;

   i2c_eeprom_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
      .dev_strap(STRAP), .wc_i(wc_i), .sda_oe(sda_oe), .busy(busy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [7:0] s, input int i);
      return s + 8'(i * 37);
   endfunction

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
      end
      m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); ack = !bus_sda; qw(); m_scl = 1'b0; qw();
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic give_ack);
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         qw(); m_scl = 1'b1; qw(); b = {b[6:0], bus_sda}; qw(); m_scl = 1'b0;
      end
      qw(); m_sda = !give_ack; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
      m_sda = 1'b1;
   endtask

   task automatic write_tx(input logic [7:0] a, input int n, input logic [7:0] seed,
                           output logic ad, output logic aa, output logic dd);
      logic k;
      i2c_start();
      send_byte({DEV, 1'b0}, ad);
      send_byte(a, aa);
      dd = 1'b1;
      for (int i = 0; i < n; i++) begin
         send_byte(pat(seed, i), k);
         dd = dd & k;
      end
      i2c_stop();
      if (!wc_i && ad)
         for (int i = 0; i < n; i++) model[{a[7:4], a[3:0] + 4'(i)}] = pat(seed, i);
   endtask

   task automatic read_rand(input logic [7:0] a, input int n);
      logic k;
      i2c_start();
      send_byte({DEV, 1'b0}, k);
      send_byte(a, k);
      i2c_start();
      send_byte({DEV, 1'b1}, k);
      for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1);
      i2c_stop();
   endtask

   task automatic read_cur();
      logic k;
      i2c_start();
      send_byte({DEV, 1'b1}, k);
      recv_byte(rbuf[0], 1'b0);
      i2c_stop();
   endtask

   task automatic wait_idle(output int bc);
      bc = 0;
      while (busy && bc < 5000) begin
         @(negedge clk);
         bc++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic ad, aa, dd, k;
      int bc;
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      repeat (10) @(negedge clk);
      chk("R1 busy after reset", busy, 0);
      chk("R1 sda_oe after reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      read_rand(8'h33, 1);
      chk("R1 memory cleared", rbuf[0], 8'h00);

      // R2: wrong strap value gets no acknowledge
      i2c_start();
      send_byte({1'b1, STRAP ^ 6'h01, 1'b0}, k);
      i2c_stop();
      chk("R2 foreign address nack", k, 0);
      chk("R2 no busy after foreign", busy, 0);

      // vector table: byte write then random read (R3, R7)
      for (int v = 0; v < 8; v++) begin
         write_tx(VEC[v][15:8], 1, VEC[v][7:0], ad, aa, dd);
         chk("R2 device address ack", ad, 1);
         chk("R3 word address ack", aa, 1);
         chk("R3 data ack", dd, 1);
         chk("R3 busy after stop", busy, 1);
         wait_idle(bc);
         if (v == 0) chk("R3 busy length", (bc >= W - 10 && bc <= W), 1);
         read_rand(VEC[v][15:8], 1);
         chk("R7 random read data", rbuf[0], VEC[v][7:0]);
      end

      // R5 and R6: commit waits for STOP, polling refused while busy
      i2c_start();
      send_byte({DEV, 1'b0}, k);
      send_byte(8'h20, k);
      send_byte(8'h99, k);
      repeat (40) @(negedge clk);
      chk("R5 no busy before stop", busy, 0);
      i2c_stop();
      model[8'h20] = 8'h99;
      chk("R5 busy after stop", busy, 1);
      i2c_start();
      send_byte({DEV, 1'b0}, k);
      i2c_stop();
      chk("R6 poll nack while busy", k, 0);
      wait_idle(bc);
      i2c_start();
      send_byte({DEV, 1'b0}, k);
      i2c_stop();
      chk("R6 poll ack when idle", k, 1);
      read_rand(8'h20, 1);
      chk("R5 committed byte", rbuf[0], 8'h99);

      // R4: 17-byte burst wraps inside the page
      write_tx(8'h47, 17, 8'h10, ad, aa, dd);
      chk("R4 burst acks", dd, 1);
      wait_idle(bc);
      chk("R4 first slot overwritten", model[8'h47], pat(8'h10, 16));
      read_rand(8'h40, 16);
      for (int j = 0; j < 16; j++) chk("R4 page contents", rbuf[j], model[8'h40 + j]);

      // R9: current address read after a random read
      read_rand(8'h43, 1);
      read_cur();
      chk("R9 current address read", rbuf[0], model[8'h44]);

      // R8: read run wraps 0xFF to 0x00
      write_tx(8'hFE, 2, 8'h60, ad, aa, dd);
      wait_idle(bc);
      read_rand(8'hFE, 3);
      chk("R8 byte at FE", rbuf[0], model[8'hFE]);
      chk("R8 byte at FF", rbuf[1], model[8'hFF]);
      chk("R8 wrapped to 00", rbuf[2], model[8'h00]);
      chk("R11 released after read", sda_oe, 0);
      read_cur();
      chk("R9 pointer after wrap", rbuf[0], model[8'h01]);

      // R10: write protect blocks data
      wc_i = 1'b1;
      write_tx(8'h90, 1, 8'h5A, ad, aa, dd);
      chk("R10 data nack", dd, 0);
      repeat (20) @(negedge clk);
      chk("R10 no busy", busy, 0);
      wc_i = 1'b0;
      read_rand(8'h90, 1);
      chk("R10 memory unchanged", rbuf[0], model[8'h90]);
      chk("R11 released at end", sda_oe, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule